// File: doc/BRIEF.md
# Output Port Register Bank for an 8-bit Stack Processor

This block converts the output instruction of an 8-bit stack processor into held output registers and single-cycle write pulses. When the processor executes an output instruction it raises an execute flag for one cycle. At the same time it presents the port number on the top-of-stack byte and the value to write on the next-on-stack byte. Every configured port compares the port number with its own 8-bit identifier. On a match, the port captures the data and, if it has a strobe, pulses it on the following cycle.

Each port carries up to two data fields, an upper field and a lower field, packed into one register. The upper field is the more significant of the two. The register loads from the low bits of the data byte, as many bits as the two fields hold together. Each field has its own reset value. A port with no field bits is a pure strobe port. One parameter selects the reset polarity at the input pin. Inside the block, reset is always active-high and synchronous.

Top module: `oport_bank`

## Requirements
- R1: On a rising clock edge where `port_exec` is 1 and `port_sel` equals a port's identifier, that port's packed register takes `port_data[TW-1:0]`, where TW = HI_W + LO_W.
- R2: A port whose identifier is not selected, or any port while `port_exec` is 0, keeps both field outputs unchanged.
- R3: The upper field is the more significant part of the packed register. Port i's upper field appears at `field_hi_o[i*8 +: 8]` as bits `port_data[TW-1:LO_W]`, and its lower field at `field_lo_o[i*8 +: 8]` as `port_data[LO_W-1:0]`. Both are zero-extended. Bits of `port_data` at or above TW are ignored.
- R4: A synchronous reset loads each field with its own configured reset value, truncated to the field width. A field configured with no reset value resets to zero.
- R5: `strobe_o[i]` of a port with a strobe is 1 for exactly the cycle after an edge at which that port was selected with `port_exec` = 1. It is 0 otherwise. Ports without a strobe hold it at 0.
- R6: The cycle after a reset edge, every strobe is 0, even if a matching write was presented at that edge.
- R7: A port with zero field bits drives both of its field outputs at 0 at all times and still produces its strobe pulse.
- R8: With RESET_ACTIVE_LOW = 1, `rst_in` = 0 resets the block. With RESET_ACTIVE_LOW = 0, `rst_in` = 1 resets it. Both polarities give the same behaviour.
- R9: A write to one port leaves every other port's field outputs unchanged.
- R10: Writes to the same port on consecutive cycles hold the strobe high on both following cycles. The register takes each written value in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_in | input | 1 | Synchronous reset, polarity set by RESET_ACTIVE_LOW |
| port_exec | input | 1 | High for the cycle in which an output instruction executes |
| port_sel | input | 8 | Top-of-stack byte, used as the port number |
| port_data | input | 8 | Next-on-stack byte, used as the written value |
| field_hi_o | output | NUM_PORTS*8 | Upper field of each port, zero-extended, port i at bits i*8 +: 8 |
| field_lo_o | output | NUM_PORTS*8 | Lower field of each port, zero-extended, port i at bits i*8 +: 8 |
| strobe_o | output | NUM_PORTS | Write pulse for each port |

## Verification
The bench uses the default configuration of four ports:

| Port | Identifier | Fields | Strobe | Reset values |
|---|---|---|---|---|
| 0 | 0x00 | one 8-bit lower field | yes | lower 0xA5 |
| 1 | 0x11 | 3-bit upper, 5-bit lower | no | upper 5, lower 0x0C |
| 2 | 0x7F | none (strobe only) | yes | none |
| 3 | 0xFF | 4-bit upper, 2-bit lower | yes | zero (default) |

This mix covers several cases:
- a full-width single field;
- split fields with and without reset values;
- a partial width, which exposes the ignoring of high data bits;
- the extreme identifiers 0x00 and 0xFF.

The bench builds a second copy with RESET_ACTIVE_LOW = 1, drives it with the same stimulus through an inverted reset, and checks it against the same expected values.

// File: rtl/oport_pkg.sv
package oport_pkg;
    localparam int BYTE_W = 8;
    localparam int WIDTH_FIELD_W = 4;

    // Low-order mask of w ones within a byte (w may be 0..8).
    function automatic logic [BYTE_W-1:0] low_mask(input int w);
        return BYTE_W'((1 << w) - 1);
    endfunction

    // Packed reset image: upper field above lower field.
    function automatic logic [BYTE_W-1:0] pack_reset(input int hw, input int lw,
                                                     input logic [BYTE_W-1:0] hv,
                                                     input logic [BYTE_W-1:0] lv);
        return BYTE_W'((int'(hv & low_mask(hw)) << lw) | int'(lv & low_mask(lw)));
    endfunction
endpackage

// File: rtl/oport_rst_cond.sv
module oport_rst_cond #(
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic rst_in,
    output logic rst_o
);
    generate
        if (ACTIVE_LOW) begin : g_low
            assign rst_o = ~rst_in;
        end else begin : g_high
            assign rst_o = rst_in;
        end
    endgenerate
endmodule

// File: rtl/oport_decode.sv
module oport_decode #(
    parameter int NUM_PORTS = 4,
    parameter logic [NUM_PORTS*8-1:0] PORT_IDS = '0
) (
    input  logic                 port_exec,
    input  logic [7:0]           port_sel,
    output logic [NUM_PORTS-1:0] hit
);
    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_cmp
            assign hit[i] = port_exec && (port_sel == PORT_IDS[i*8 +: 8]);
        end
    endgenerate
endmodule

// File: rtl/oport_slot.sv
module oport_slot
    import oport_pkg::*;
#(
    parameter int              HW      = 0,
    parameter int              LW      = 8,
    parameter logic [7:0]      HI_RST  = 8'h00,
    parameter logic [7:0]      LO_RST  = 8'h00,
    parameter bit              HAS_STB = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    input  logic [7:0] data,
    output logic [7:0] hi_o,
    output logic [7:0] lo_o,
    output logic       stb_o
);
    localparam int         TW    = HW + LW;
    localparam logic [7:0] HMASK = low_mask(HW);
    localparam logic [7:0] LMASK = low_mask(LW);
    localparam logic [7:0] TMASK = low_mask(TW);
    localparam logic [7:0] RSTV  = pack_reset(HW, LW, HI_RST, LO_RST);

    generate
        if (TW > 0) begin : g_reg
            logic [7:0] pack_q;
            always_ff @(posedge clk) begin
                if (rst)
                    pack_q <= RSTV;
                else if (hit)
                    pack_q <= data & TMASK;
            end
            assign hi_o = (pack_q >> LW) & HMASK;
            assign lo_o = pack_q & LMASK;
        end else begin : g_noreg
            assign hi_o = 8'h00;
            assign lo_o = 8'h00;
        end

        if (HAS_STB) begin : g_stb
            logic stb_q;
            always_ff @(posedge clk) begin
                if (rst)
                    stb_q <= 1'b0;
                else
                    stb_q <= hit;
            end
            assign stb_o = stb_q;
        end else begin : g_nostb
            assign stb_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/oport_bank.sv
module oport_bank #(
    parameter int                      NUM_PORTS        = 4,
    parameter logic [NUM_PORTS*8-1:0]  PORT_IDS         = {8'hFF, 8'h7F, 8'h11, 8'h00},
    parameter logic [NUM_PORTS*4-1:0]  HI_W             = {4'd4, 4'd0, 4'd3, 4'd0},
    parameter logic [NUM_PORTS*4-1:0]  LO_W             = {4'd2, 4'd0, 4'd5, 4'd8},
    parameter logic [NUM_PORTS*8-1:0]  HI_INIT          = {8'h00, 8'h00, 8'h05, 8'h00},
    parameter logic [NUM_PORTS*8-1:0]  LO_INIT          = {8'h00, 8'h00, 8'h0C, 8'hA5},
    parameter logic [NUM_PORTS-1:0]    STROBE_EN        = 4'b1101,
    parameter bit                      RESET_ACTIVE_LOW = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst_in,
    input  logic                   port_exec,
    input  logic [7:0]             port_sel,
    input  logic [7:0]             port_data,
    output logic [NUM_PORTS*8-1:0] field_hi_o,
    output logic [NUM_PORTS*8-1:0] field_lo_o,
    output logic [NUM_PORTS-1:0]   strobe_o
);
    logic                 rst_int;
    logic [NUM_PORTS-1:0] hit;

    oport_rst_cond #(.ACTIVE_LOW(RESET_ACTIVE_LOW)) u_rst (
        .rst_in (rst_in),
        .rst_o  (rst_int)
    );

    oport_decode #(.NUM_PORTS(NUM_PORTS), .PORT_IDS(PORT_IDS)) u_dec (
        .port_exec (port_exec),
        .port_sel  (port_sel),
        .hit       (hit)
    );

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
            oport_slot #(
                .HW      (int'(HI_W[i*4 +: 4])),
                .LW      (int'(LO_W[i*4 +: 4])),
                .HI_RST  (HI_INIT[i*8 +: 8]),
                .LO_RST  (LO_INIT[i*8 +: 8]),
                .HAS_STB (STROBE_EN[i])
            ) u_slot (
                .clk   (clk),
                .rst   (rst_int),
                .hit   (hit[i]),
                .data  (port_data),
                .hi_o  (field_hi_o[i*8 +: 8]),
                .lo_o  (field_lo_o[i*8 +: 8]),
                .stb_o (strobe_o[i])
            );
        end
    endgenerate
endmodule

// File: rtl/oport_bank_chk.sv
module oport_bank_chk
    import oport_pkg::*;
#(
    parameter int                     NUM_PORTS = 4,
    parameter logic [NUM_PORTS*8-1:0] PORT_IDS  = '0,
    parameter logic [NUM_PORTS*4-1:0] HI_W      = '0,
    parameter logic [NUM_PORTS*4-1:0] LO_W      = '0,
    parameter logic [NUM_PORTS*8-1:0] HI_INIT   = '0,
    parameter logic [NUM_PORTS*8-1:0] LO_INIT   = '0,
    parameter logic [NUM_PORTS-1:0]   STROBE_EN = '0
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   port_exec,
    input logic [7:0]             port_sel,
    input logic [7:0]             port_data,
    input logic [NUM_PORTS*8-1:0] field_hi_o,
    input logic [NUM_PORTS*8-1:0] field_lo_o,
    input logic [NUM_PORTS-1:0]   strobe_o
);
    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= rst;

    generate
        for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
            localparam int         HW = int'(HI_W[i*4 +: 4]);
            localparam int         LW = int'(LO_W[i*4 +: 4]);
            localparam logic [7:0] ID = PORT_IDS[i*8 +: 8];
            localparam logic [7:0] HM = low_mask(HW);
            localparam logic [7:0] LM = low_mask(LW);

            if (HW + LW > 0) begin : g_fld
                // R1 and R3: captured value lands in the packed fields
                p_load_r1: assert property (@(posedge clk) disable iff (rst)
                    (port_exec && port_sel == ID) |=>
                    (field_lo_o[i*8 +: 8] == ($past(port_data) & LM)) &&
                    (field_hi_o[i*8 +: 8] == (($past(port_data) >> LW) & HM)));
            end

            // R2 and R9: unselected ports hold
            p_hold_r2: assert property (@(posedge clk) disable iff (rst)
                !(port_exec && port_sel == ID) |=>
                $stable(field_hi_o[i*8 +: 8]) && $stable(field_lo_o[i*8 +: 8]));

            if (STROBE_EN[i]) begin : g_stb
                // R5: pulse follows a matching write
                p_pulse_r5: assert property (@(posedge clk) disable iff (rst)
                    (port_exec && port_sel == ID) |=> strobe_o[i]);
            end

            // R5: no pulse without a matching write
            p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
                !(port_exec && port_sel == ID) |=> !strobe_o[i]);

            // R4: fields carry their reset images after a reset edge
            always_ff @(posedge clk) begin
                if (rst_seen) begin
                    p_init_r4: assert ((field_hi_o[i*8 +: 8] == (HI_INIT[i*8 +: 8] & HM)) &&
                                       (field_lo_o[i*8 +: 8] == (LO_INIT[i*8 +: 8] & LM)));
                end
            end
        end
    endgenerate

    // R6: strobes are low after a reset edge
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            p_stb_reset_r6: assert (strobe_o == '0);
        end
    end
endmodule

bind oport_bank oport_bank_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_IDS  (PORT_IDS),
    .HI_W      (HI_W),
    .LO_W      (LO_W),
    .HI_INIT   (HI_INIT),
    .LO_INIT   (LO_INIT),
    .STROBE_EN (STROBE_EN)
) u_chk (
    .clk        (clk),
    .rst        (rst_int),
    .port_exec  (port_exec),
    .port_sel   (port_sel),
    .port_data  (port_data),
    .field_hi_o (field_hi_o),
    .field_lo_o (field_lo_o),
    .strobe_o   (strobe_o)
);

// File: tb/oport_bank_test.sv
`timescale 1ns/1ps
module oport_bank_test;
    localparam int N = 4;
    localparam logic [7:0] IDS   [N] = '{8'h00, 8'h11, 8'h7F, 8'hFF};
    localparam int         HWS   [N] = '{0, 3, 0, 4};
    localparam int         LWS   [N] = '{8, 5, 0, 2};
    localparam logic [7:0] HINIT [N] = '{8'h00, 8'h05, 8'h00, 8'h00};
    localparam logic [7:0] LINIT [N] = '{8'hA5, 8'h0C, 8'h00, 8'h00};
    localparam bit         STBEN [N] = '{1'b1, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       exec = 1'b0;
    logic [7:0] sel = 8'h00;
    logic [7:0] data = 8'h00;
    logic [N*8-1:0] hi_a, lo_a, hi_b, lo_b;
    logic [N-1:0]   stb_a, stb_b;

    oport_bank uut (
        .clk(clk), .rst_in(rst), .port_exec(exec), .port_sel(sel), .port_data(data),
        .field_hi_o(hi_a), .field_lo_o(lo_a), .strobe_o(stb_a));

    oport_bank #(.RESET_ACTIVE_LOW(1'b1)) uut_n (
        .clk(clk), .rst_in(~rst), .port_exec(exec), .port_sel(sel), .port_data(data),
        .field_hi_o(hi_b), .field_lo_o(lo_b), .strobe_o(stb_b));

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] m_pack [N];
    logic       m_stb  [N];

    function automatic logic [7:0] msk(input int w);
        return 8'((1 << w) - 1);
    endfunction

    function automatic logic [7:0] exp_hi(input int i);
        return (m_pack[i] >> LWS[i]) & msk(HWS[i]);
    endfunction

    function automatic logic [7:0] exp_lo(input int i);
        return m_pack[i] & msk(LWS[i]);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_pack[i] = 8'(((int'(HINIT[i] & msk(HWS[i]))) << LWS[i]) | int'(LINIT[i] & msk(LWS[i])));
            m_stb[i]  = 1'b0;
        end
    endtask

    task automatic model_step(input logic e, input logic [7:0] s, input logic [7:0] d);
        for (int i = 0; i < N; i++) begin
            logic h;
            h = e && (s == IDS[i]);
            if (h) m_pack[i] = d & msk(HWS[i] + LWS[i]);
            m_stb[i] = h && STBEN[i];
        end
    endtask

    task automatic cmp(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < N; i++) begin
            cmp({tag, " hi"},  hi_a[i*8 +: 8], exp_hi(i));
            cmp({tag, " lo"},  lo_a[i*8 +: 8], exp_lo(i));
            cmp({tag, " stb"}, {7'd0, stb_a[i]}, {7'd0, m_stb[i]});
            cmp({tag, " R8 hi"},  hi_b[i*8 +: 8], exp_hi(i));
            cmp({tag, " R8 lo"},  lo_b[i*8 +: 8], exp_lo(i));
            cmp({tag, " R8 stb"}, {7'd0, stb_b[i]}, {7'd0, m_stb[i]});
        end
    endtask

    // One clock cycle: drive at the falling edge, check just after the rising edge.
    task automatic step(input logic r, input logic e, input logic [7:0] s,
                        input logic [7:0] d, input string tag);
        @(negedge clk);
        rst = r; exec = e; sel = s; data = d;
        @(posedge clk);
        if (r) model_reset(); else model_step(e, s, d);
        #1;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0A17));
        model_reset();
        // R4 R6 R8: reset state, with a matching write masked by reset
        step(1'b1, 1'b0, 8'h00, 8'h00, "R4 reset");
        step(1'b1, 1'b1, 8'h00, 8'h3C, "R6 reset wins");
        // R1 R3: full-width field and split fields
        step(1'b0, 1'b1, 8'h00, 8'h5A, "R1 port0");
        step(1'b0, 1'b1, 8'h11, 8'hB7, "R3 split");
        // R3: high data bits above the packed width ignored
        step(1'b0, 1'b1, 8'hFF, 8'hFF, "R3 upper ignored");
        step(1'b0, 1'b1, 8'hFF, 8'hC6, "R3 partial");
        // R7: strobe-only port
        step(1'b0, 1'b1, 8'h7F, 8'hFF, "R7 strobe only");
        // R2 R9: unknown port and exec low
        step(1'b0, 1'b1, 8'h42, 8'h99, "R9 other port");
        step(1'b0, 1'b0, 8'h00, 8'h01, "R2 exec low");
        // R10: back-to-back writes to one port
        step(1'b0, 1'b1, 8'h00, 8'h12, "R10 first");
        step(1'b0, 1'b1, 8'h00, 8'h34, "R10 second");
        step(1'b0, 1'b0, 8'h00, 8'h00, "R5 pulse ends");
        // Constrained random mix
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] s;
            logic r;
            s = ($urandom_range(0, 3) == 0) ? 8'($urandom) : IDS[$urandom_range(0, N - 1)];
            r = ($urandom_range(0, 199) == 0);
            step(r, 1'($urandom_range(0, 1)), s, 8'($urandom), "R5 random");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule